// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the protocol side of an 8192-byte serial EEPROM that sits on a two-wire bus as a slave. It runs on a fast system clock. Its inputs are the bus clock and data levels, already synchronised, along with single-cycle strobes that mark start and stop conditions. Its only bus output is an open-drain pull-low enable for the data line. The controller decodes the select byte, captures a two-byte word address and then steps through one of several transfers:

- a single-byte write or a page write;
- a read from the current address;
- a random read, made of a dummy write followed by a repeated start;
- a sequential read.

The controller reads the storage array through a synchronous read port, where data is valid one cycle after the enable. It does not write the array itself. Instead it hands every accepted write byte, with its address, to a separate page-write engine, and then signals the engine to commit once the write ends correctly. While the engine reports busy, the controller will not acknowledge a select byte. A master can use this to poll until the write cycle has finished.

Top module: `sereep_slave`

## Requirements
- R1: A select byte is received MSB first and acknowledged (data pulled low in the 9th clock) only when bits 7..4 equal 1010 and bits 3..1 equal `chip_pins[2:0]`. Bit 0 selects the direction: 1 means read, 0 means write.
- R2: After a select byte that does not match, the data line stays released for every following byte until the next start condition.
- R3: After a write select, two address bytes are taken, high byte first, and each is acknowledged. The low 13 bits of the 16-bit value form the word address.
- R4: Each data byte of a write is acknowledged and appears on `pw_data`, with its address on `pw_addr`, during a one-cycle `pw_vld` pulse. Between bytes only address bits 4..0 advance, wrapping inside the 32-byte row, and bits 12..5 are held.
- R5: A stop that arrives directly after the acknowledge of a data byte produces a one-cycle `pw_commit` pulse. A stop at any other point produces no `pw_commit` pulse.
- R6: When `wr_lock` is high at the moment the second address byte is acknowledged, data bytes aimed at 0x1800..0x1FFF are still acknowledged, but they produce no `pw_vld`.
- R7: A random read loads the address through a dummy write, then takes a repeated start and a read select. It returns the byte at that address, MSB first.
- R8: A read select with no address phase returns the byte at the internal counter. The counter advances after every byte read. After a write, the counter holds the last written address plus one, wrapped within the row.
- R9: During a read, a master acknowledge in the 9th clock causes the next consecutive byte to be sent. A master no-acknowledge ends the transfer, and the controller stays released until the next start.
- R10: A sequential read wraps from 0x1FFF to 0x0000.
- R11: Reads return array data regardless of `wr_lock`.
- R12: While `eng_busy` is high, a select byte is not acknowledged and the data line stays released.
- R13: After reset the data line is released. A pull on the data line only begins after a falling edge of the bus clock. The controller releases the line during the master's acknowledge slot of each read byte.
- R14: A start condition at any point aborts the operation in progress and returns to select-byte reception. The address counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_lvl | input | 1 | Synchronised bus clock level |
| sda_lvl | input | 1 | Synchronised bus data level |
| start_stb | input | 1 | One-cycle start or repeated-start strobe |
| stop_stb | input | 1 | One-cycle stop strobe |
| chip_pins | input | 3 | Strapped chip address |
| wr_lock | input | 1 | Protects the top quarter of the array from writes |
| eng_busy | input | 1 | Page-write engine is running a write cycle |
| mem_rdata | input | 8 | Array read data, valid one cycle after `mem_ren` |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| mem_ren | output | 1 | Array read enable |
| mem_raddr | output | 13 | Array read address |
| pw_vld | output | 1 | Write byte strobe to the page-write engine |
| pw_addr | output | 13 | Address of the write byte |
| pw_data | output | 8 | Write byte |
| pw_commit | output | 1 | Start the engine's write cycle |

## Verification
The hardest state to reach from the ports is the address counter at its final location, part-way through a sequential read, with the write lock raised. The stimulus gets there with a random read that loads 0x1FFE through a dummy write. It then acknowledges two bytes and refuses the third, so the wrap to 0x0000 and the lock-independence of reads are both seen on the bus. A second hard case is the row wrap of a page write. Writing three bytes from 0x003E shows it directly on `pw_addr`. A current-address read that follows then reveals the counter value the write left behind.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
    localparam logic [3:0] TYPE_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } st_e;
endpackage

// File: rtl/sereep_sclmon.sv
module sereep_sclmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    output logic rise,
    output logic fall
);
    logic scl_d, scl_q;

    always_comb scl_d = scl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_d;
    end

    assign rise = scl & ~scl_q;
    assign fall = ~scl & scl_q;
endmodule

// File: rtl/sereep_actr.sv
module sereep_actr #(
    parameter int AW = 13,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_row,
    input  logic          inc_full,
    output logic [AW-1:0] q
);
    logic [AW-1:0] ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load)
            ctr_d = load_val;
        else if (inc_full)
            ctr_d = ctr_q + 1'b1;
        else if (inc_row)
            ctr_d = {ctr_q[AW-1:PW], ctr_q[PW-1:0] + 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign q = ctr_q;

    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full && !load && ctr_q == '1) |=> (ctr_q == '0)); // R10

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_row && !inc_full && !load) |=> (ctr_q[AW-1:PW] == $past(ctr_q[AW-1:PW]))); // R4
endmodule

// File: rtl/sereep_slave.sv
module sereep_slave
    import sereep_pkg::*;
#(
    parameter int AW = 13,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          start_stb,
    input  logic          stop_stb,
    input  logic [2:0]    chip_pins,
    input  logic          wr_lock,
    input  logic          eng_busy,
    input  logic [7:0]    mem_rdata,
    output logic          sda_pull,
    output logic          mem_ren,
    output logic [AW-1:0] mem_raddr,
    output logic          pw_vld,
    output logic [AW-1:0] pw_addr,
    output logic [7:0]    pw_data,
    output logic          pw_commit
);
    localparam int HW = AW - 8;

    typedef struct packed {
        st_e           st;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [HW-1:0] hi;
        logic          pull;
        logic          mack;
        logic          ren;
        logic          vld;
        logic [AW-1:0] wa;
        logic [7:0]    wd;
        logic          commit;
        logic          lock;
        logic          wr_any;
    } fsm_t;

    fsm_t r_q, r_d;

    logic          rise, fall;
    logic          ld, inc_row, inc_full;
    logic [AW-1:0] ctr;
    logic          sel_ok;
    logic          top_qtr;

    sereep_sclmon u_mon (
        .clk  (clk),
        .rst_n(rst_n),
        .scl  (scl_lvl),
        .rise (rise),
        .fall (fall)
    );

    sereep_actr #(.AW(AW), .PW(PW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld),
        .load_val({r_q.hi, r_q.sh}),
        .inc_row (inc_row),
        .inc_full(inc_full),
        .q       (ctr)
    );

    assign sel_ok  = (r_q.sh[7:4] == TYPE_CODE) && (r_q.sh[3:1] == chip_pins) && !eng_busy;
    assign top_qtr = (ctr[AW-1 -: 2] == 2'b11);

    always_comb begin
        r_d        = r_q;
        r_d.ren    = 1'b0;
        r_d.vld    = 1'b0;
        r_d.commit = 1'b0;
        ld         = 1'b0;
        inc_row    = 1'b0;
        inc_full   = 1'b0;

        if (start_stb) begin
            r_d.st     = ST_SEL;
            r_d.cnt    = '0;
            r_d.pull   = 1'b0;
            r_d.wr_any = 1'b0;
        end else if (stop_stb) begin
            if (r_q.st == ST_WR && r_q.cnt == 4'd1 && r_q.wr_any)
                r_d.commit = 1'b1;
            r_d.st     = ST_IDLE;
            r_d.cnt    = '0;
            r_d.pull   = 1'b0;
            r_d.wr_any = 1'b0;
        end else begin
            case (r_q.st)
                ST_SEL, ST_AHI, ST_ALO, ST_WR: begin
                    if (rise) begin
                        if (r_q.cnt < 4'd8) begin
                            r_d.sh  = {r_q.sh[6:0], sda_lvl};
                            r_d.cnt = r_q.cnt + 1'b1;
                        end else if (r_q.cnt == 4'd8) begin
                            r_d.cnt = 4'd9;
                        end
                    end else if (fall) begin
                        if (r_q.cnt == 4'd8) begin
                            case (r_q.st)
                                ST_SEL: begin
                                    if (sel_ok) begin
                                        r_d.pull = 1'b1;
                                        r_d.ren  = r_q.sh[0];
                                    end else begin
                                        r_d.st  = ST_IDLE;
                                        r_d.cnt = '0;
                                    end
                                end
                                ST_AHI: begin
                                    r_d.pull = 1'b1;
                                    r_d.hi   = r_q.sh[HW-1:0];
                                end
                                ST_ALO: begin
                                    r_d.pull = 1'b1;
                                    r_d.lock = wr_lock;
                                    ld       = 1'b1;
                                end
                                default: begin
                                    r_d.pull   = 1'b1;
                                    r_d.wa     = ctr;
                                    r_d.wd     = r_q.sh;
                                    r_d.vld    = !(r_q.lock && top_qtr);
                                    r_d.wr_any = 1'b1;
                                    inc_row    = 1'b1;
                                end
                            endcase
                        end else if (r_q.cnt == 4'd9) begin
                            r_d.pull = 1'b0;
                            r_d.cnt  = '0;
                            case (r_q.st)
                                ST_SEL: begin
                                    if (r_q.sh[0]) begin
                                        r_d.st   = ST_RD;
                                        r_d.sh   = mem_rdata;
                                        r_d.pull = ~mem_rdata[7];
                                    end else begin
                                        r_d.st = ST_AHI;
                                    end
                                end
                                ST_AHI:  r_d.st = ST_ALO;
                                default: r_d.st = ST_WR;
                            endcase
                        end
                    end
                end
                ST_RD: begin
                    if (rise) begin
                        if (r_q.cnt < 4'd8) begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end else if (r_q.cnt == 4'd8) begin
                            r_d.mack = ~sda_lvl;
                            r_d.cnt  = 4'd9;
                        end
                    end else if (fall) begin
                        if (r_q.cnt >= 4'd1 && r_q.cnt <= 4'd7) begin
                            r_d.sh   = {r_q.sh[6:0], 1'b0};
                            r_d.pull = ~r_q.sh[6];
                        end else if (r_q.cnt == 4'd8) begin
                            r_d.pull = 1'b0;
                            r_d.ren  = 1'b1;
                            inc_full = 1'b1;
                        end else if (r_q.cnt == 4'd9) begin
                            r_d.cnt = '0;
                            if (r_q.mack) begin
                                r_d.sh   = mem_rdata;
                                r_d.pull = ~mem_rdata[7];
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull  = r_q.pull;
    assign mem_ren   = r_q.ren;
    assign mem_raddr = ctr;
    assign pw_vld    = r_q.vld;
    assign pw_addr   = r_q.wa;
    assign pw_data   = r_q.wd;
    assign pw_commit = r_q.commit;

    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(fall)); // R13

    AST_RD_ACKSLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD && r_q.cnt == 4'd9) |-> !sda_pull); // R13

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !start_stb && !stop_stb && r_q.st == ST_SEL && r_q.cnt == 4'd8 && eng_busy)
        |=> !sda_pull); // R12

    AST_COMMIT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pw_commit |-> ($past(r_q.st) == ST_WR)); // R5

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !sda_pull); // R2
endmodule

// File: tb/tb_sereep_slave.sv
module tb_sereep_slave;
    localparam int CLK_P = 10;
    localparam int Q     = 6;
    localparam logic [2:0] PINS = 3'b011;
    localparam logic [7:0] SEL_W = {4'b1010, PINS, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, PINS, 1'b1};

    logic clk = 0, rst_n = 0;
    logic m_scl = 1, m_sda = 1, start_stb = 0, stop_stb = 0;
    logic wr_lock = 0, eng_busy = 0;
    logic [7:0] mem_rdata = '0;
    logic sda_pull, mem_ren, pw_vld, pw_commit;
    logic [12:0] mem_raddr, pw_addr;
    logic [7:0] pw_data;
    wire sda_line = m_sda & ~sda_pull;

    int total = 0, bad = 0;
    int pw_n = 0, com_n = 0;
    logic [12:0] log_a [0:15];
    logic [7:0]  log_d [0:15];
    logic [7:0]  bmem [0:8191];

    always #(CLK_P/2) clk = ~clk;

    sereep_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_lvl(m_scl), .sda_lvl(sda_line),
        .start_stb(start_stb), .stop_stb(stop_stb), .chip_pins(PINS),
        .wr_lock(wr_lock), .eng_busy(eng_busy), .mem_rdata(mem_rdata),
        .sda_pull(sda_pull), .mem_ren(mem_ren), .mem_raddr(mem_raddr),
        .pw_vld(pw_vld), .pw_addr(pw_addr), .pw_data(pw_data), .pw_commit(pw_commit)
    );

    always @(posedge clk) if (mem_ren) mem_rdata <= bmem[mem_raddr];

    always @(negedge clk) if (rst_n) begin
        if (pw_vld) begin
            log_a[pw_n % 16] = pw_addr;
            log_d[pw_n % 16] = pw_data;
            bmem[pw_addr] = pw_data;
            pw_n++;
        end
        if (pw_commit) com_n++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1; tick(Q); m_scl = 1; tick(Q);
        m_sda = 0; start_stb = 1; tick(1); start_stb = 0;
        tick(Q); m_scl = 0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 0; tick(Q); m_scl = 1; tick(Q);
        m_sda = 1; stop_stb = 1; tick(1); stop_stb = 0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q); m_scl = 1; tick(Q); m_scl = 0;
        end
        m_sda = 1; tick(Q); m_scl = 1; tick(Q/2);
        ack = ~sda_line;
        tick(Q - Q/2); m_scl = 0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_scl = 1; tick(Q/2); b[i] = sda_line; tick(Q - Q/2); m_scl = 0;
        end
        m_sda = ~mack; tick(Q); m_scl = 1; tick(Q/2);
        if (!mack) chk("R13 released in master ack slot", sda_line, 1);
        tick(Q - Q/2); m_scl = 0; tick(1); m_sda = 1;
    endtask

    task automatic rd_setup(input logic [12:0] a, output logic ok);
        logic k1, k2, k3, k4;
        bus_start(); send_byte(SEL_W, k1);
        send_byte({3'b000, a[12:8]}, k2); send_byte(a[7:0], k3);
        bus_start(); send_byte(SEL_R, k4);
        ok = k1 & k2 & k3 & k4;
    endtask

    task automatic t_reset();
        chk("R13 reset sda released", sda_pull, 0);
        chk("R13 reset no strobes", {pw_vld, pw_commit, mem_ren}, 0);
    endtask

    task automatic t_mismatch();
        logic k;
        bus_start(); send_byte(8'hA0, k); chk("R2 wrong pins nack", k, 0);
        send_byte(8'h55, k); chk("R2 later byte ignored", k, 0); bus_stop();
        bus_start(); send_byte({4'b1011, PINS, 1'b0}, k); chk("R1 wrong type nack", k, 0); bus_stop();
    endtask

    task automatic t_write_byte();
        logic k; int n0 = pw_n, c0 = com_n;
        bus_start(); send_byte(SEL_W, k); chk("R1 select ack", k, 1);
        send_byte(8'h01, k); chk("R3 addr hi ack", k, 1);
        send_byte(8'h23, k); chk("R3 addr lo ack", k, 1);
        send_byte(8'h5A, k); chk("R4 data ack", k, 1);
        chk("R4 one strobe", pw_n - n0, 1);
        chk("R4 addr", log_a[n0 % 16], 13'h0123);
        chk("R4 data", log_d[n0 % 16], 8'h5A);
        bus_stop(); chk("R5 commit", com_n - c0, 1);
    endtask

    task automatic t_page_wrap();
        logic k; logic [7:0] b; int n0 = pw_n, c0 = com_n; logic [7:0] exp21 = bmem[13'h21];
        bus_start(); send_byte(SEL_W, k); send_byte(8'h00, k); send_byte(8'h3E, k);
        send_byte(8'h11, k); send_byte(8'h22, k); send_byte(8'h33, k);
        chk("R4 row addr 0", log_a[n0 % 16], 13'h003E);
        chk("R4 row addr 1", log_a[(n0+1) % 16], 13'h003F);
        chk("R4 row wrap", log_a[(n0+2) % 16], 13'h0020);
        bus_stop(); chk("R5 page commit", com_n - c0, 1);
        bus_start(); send_byte(SEL_R, k); chk("R8 current select ack", k, 1);
        recv_byte(0, b); chk("R8 counter after write", b, exp21); bus_stop();
    endtask

    task automatic t_no_commit();
        logic k; int c0 = com_n;
        bus_start(); send_byte(SEL_W, k); send_byte(8'h04, k); send_byte(8'h00, k);
        bus_stop(); chk("R5 stop without data no commit", com_n - c0, 0);
    endtask

    task automatic t_lock();
        logic k; logic [7:0] b; int n0; logic [7:0] orig = bmem[13'h1FF0];
        wr_lock = 1; n0 = pw_n;
        bus_start(); send_byte(SEL_W, k); send_byte(8'h1F, k); send_byte(8'hF0, k);
        send_byte(8'h77, k); chk("R6 locked byte still acked", k, 1);
        chk("R6 no strobe in top quarter", pw_n - n0, 0); bus_stop();
        rd_setup(13'h1FF0, k); recv_byte(0, b); bus_stop();
        chk("R6 locked location unchanged", b, orig);
        n0 = pw_n;
        bus_start(); send_byte(SEL_W, k); send_byte(8'h01, k); send_byte(8'h00, k);
        send_byte(8'h66, k); chk("R6 low area written", pw_n - n0, 1); bus_stop();
        wr_lock = 0;
    endtask

    task automatic t_random();
        logic k; logic [7:0] b;
        rd_setup(13'h0ABC, k); chk("R7 read select ack", k, 1);
        recv_byte(0, b); chk("R7 random data", b, bmem[13'h0ABC]);
        chk("R9 released after nack", sda_pull, 0); bus_stop();
    endtask

    task automatic t_seq_wrap();
        logic k; logic [7:0] b0, b1, b2;
        wr_lock = 1;
        rd_setup(13'h1FFE, k);
        recv_byte(1, b0); recv_byte(1, b1); recv_byte(0, b2); bus_stop();
        chk("R11 read under lock", b0, bmem[13'h1FFE]);
        chk("R9 next byte on ack", b1, bmem[13'h1FFF]);
        chk("R10 wrap to zero", b2, bmem[13'h0000]);
        wr_lock = 0;
    endtask

    task automatic t_current();
        logic k; logic [7:0] b;
        bus_start(); send_byte(SEL_R, k); recv_byte(0, b); bus_stop();
        chk("R8 current read follows", b, bmem[13'h0001]);
    endtask

    task automatic t_busy();
        logic k;
        eng_busy = 1;
        bus_start(); send_byte(SEL_W, k); chk("R12 busy nack write", k, 0); bus_stop();
        bus_start(); send_byte(SEL_R, k); chk("R12 busy nack read", k, 0); bus_stop();
        eng_busy = 0;
        bus_start(); send_byte(SEL_W, k); chk("R12 ack when idle", k, 1); bus_stop();
    endtask

    task automatic t_abort();
        logic k; logic [7:0] b;
        bus_start(); send_byte(SEL_W, k); send_byte(8'h05, k);
        bus_start(); send_byte(SEL_R, k); chk("R14 select after abort", k, 1);
        recv_byte(0, b); bus_stop();
        chk("R14 counter kept", b, bmem[13'h0002]);
    endtask

    initial begin
        for (int a = 0; a < 8192; a++) bmem[a] = 8'((a * 29 + (a >> 8)) ^ 8'h5C);
        tick(5); t_reset(); rst_n = 1; tick(3);
        t_reset();
        t_mismatch();
        t_write_byte();
        t_page_wrap();
        t_no_commit();
        t_lock();
        t_random();
        t_seq_wrap();
        t_current();
        t_busy();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        total++; bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule